// File: doc/BRIEF.md
# Effective Address Former

This block computes the 16-bit address an 8-bit processor core uses for the current instruction. The decoder supplies an addressing-mode code, the operand bytes that follow the opcode, the address of the first byte after the opcode, and the program counter of the following instruction. The block also receives both index registers, a bit that selects the second index register (set when the instruction came through the alternate opcode page), and the result of the branch condition test. It returns one of two things: the memory address of the argument, or, for branches, the program counter from which execution continues.

The result is registered. One clock after `in_valid` is sampled high, `ea` and `is_mem` show the result and `ea_valid` is high for exactly one cycle. When `in_valid` is low, `ea` and `is_mem` keep their last values. All sums wrap modulo 65536 and raise no flag.

Top module: `ea_former`

## Requirements
- R1: `ea_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R2: Mode 2 (direct) gives `ea = {8'h00, opnd0}`, so results stay within 0x0000 to 0x00FF.
- R3: Mode 3 (extended) gives `ea = {opnd0, opnd1}`, where the first operand byte is the high byte.
- R4: Mode 4 (indexed) gives `ea = base + zero_extend(opnd0)`. The base is `iy` when `sel_y` is 1 and `ix` otherwise.
- R5: Mode 5 (relative) with `br_taken` = 1 gives `ea = pc_next + sign_extend(opnd0)`.
- R6: Mode 5 with `br_taken` = 0 gives `ea = pc_next`.
- R7: Mode 1 (immediate) gives `ea = opnd_addr`.
- R8: Mode 0 (inherent), and the unused codes 6 and 7, give `ea = 0` and `is_mem = 0`.
- R9: `is_mem` is 1 for modes 1, 2, 3 and 4, and 0 for modes 0, 5, 6 and 7.
- R10: The sums in R4 and R5 wrap modulo 2^16.
- R11: While `in_valid` is low, `ea` and `is_mem` hold their values.
- R12: After reset, `ea` is 0 and `ea_valid` and `is_mem` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| mode | input | 3 | Addressing mode: 0 inherent, 1 immediate, 2 direct, 3 extended, 4 indexed, 5 relative |
| opnd0 | input | 8 | First operand byte after the opcode |
| opnd1 | input | 8 | Second operand byte |
| opnd_addr | input | 16 | Address of the byte after the opcode |
| pc_next | input | 16 | Program counter past the whole instruction |
| ix | input | 16 | First index register |
| iy | input | 16 | Second index register |
| sel_y | input | 1 | Use `iy` as the indexed base |
| br_taken | input | 1 | The branch condition is true |
| ea | output | 16 | Effective address or branch target |
| ea_valid | output | 1 | `ea` is new this cycle |
| is_mem | output | 1 | `ea` addresses a memory argument |

## Verification
The bench applies all 256 offsets in indexed mode, with both index registers and with bases near 0xFFFF. A design that sign-extends the indexed offset would then produce addresses below the base, and one that ignores `sel_y` would produce the wrong base. It applies all 256 relative offsets, taken and not taken, around a program counter near both ends of the address space. This exposes a zero-extended branch offset and any failure to wrap. It also drives every direct operand, checks that extended mode puts the high byte first, and applies the unused mode codes. Idle cycles with changed inputs confirm that a design which updates its result without `in_valid` is caught.

// File: rtl/ea_former.sv
module ea_former (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  mode,
  input  logic [7:0]  opnd0,
  input  logic [7:0]  opnd1,
  input  logic [15:0] opnd_addr,
  input  logic [15:0] pc_next,
  input  logic [15:0] ix,
  input  logic [15:0] iy,
  input  logic        sel_y,
  input  logic        br_taken,
  output logic [15:0] ea,
  output logic        ea_valid,
  output logic        is_mem
);
  localparam logic [2:0] M_INH = 3'd0, M_IMM = 3'd1, M_DIR = 3'd2,
                         M_EXT = 3'd3, M_IDX = 3'd4, M_REL = 3'd5;

  logic [15:0] base, next_ea;
  logic        next_mem;

  assign base = sel_y ? iy : ix;

  always_comb begin
    next_ea  = 16'h0000;
    next_mem = 1'b0;
    case (mode)
      M_IMM: begin next_ea = opnd_addr;              next_mem = 1'b1; end
      M_DIR: begin next_ea = {8'h00, opnd0};         next_mem = 1'b1; end
      M_EXT: begin next_ea = {opnd0, opnd1};         next_mem = 1'b1; end
      M_IDX: begin next_ea = base + {8'h00, opnd0};  next_mem = 1'b1; end
      M_REL: next_ea = br_taken ? pc_next + {{8{opnd0[7]}}, opnd0} : pc_next;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea       <= 16'h0000;
      ea_valid <= 1'b0;
      is_mem   <= 1'b0;
    end else begin
      ea_valid <= in_valid;
      if (in_valid) begin
        ea     <= next_ea;
        is_mem <= next_mem;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ea_valid);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !ea_valid);
  assert_direct_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == M_DIR) |=> (ea[15:8] == 8'h00 && is_mem));
  assert_fallthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == M_REL && !br_taken) |=> (ea == $past(pc_next) && !is_mem));
  assert_inherent_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == M_INH || mode > M_REL)) |=> (ea == 16'h0000 && !is_mem));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(ea) && $stable(is_mem)));
endmodule

// File: tb/ea_former_bench.sv
`timescale 1ns/1ps
module ea_former_bench;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, sel_y = 1'b0, br_taken = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  opnd0 = 8'h00, opnd1 = 8'h00;
  logic [15:0] opnd_addr = 16'h0, pc_next = 16'h0, ix = 16'h0, iy = 16'h0;
  logic [15:0] ea;
  logic        ea_valid, is_mem;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ea_former u_ea_former (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .opnd0(opnd0), .opnd1(opnd1), .opnd_addr(opnd_addr), .pc_next(pc_next),
    .ix(ix), .iy(iy), .sel_y(sel_y), .br_taken(br_taken),
    .ea(ea), .ea_valid(ea_valid), .is_mem(is_mem));

  task automatic check(string req, logic [15:0] exp_ea, logic exp_v, logic exp_m);
    tests++;
    if (ea !== exp_ea || ea_valid !== exp_v || is_mem !== exp_m) begin
      fails++;
      $display("FAIL %s: ea=%h v=%b mem=%b expected ea=%h v=%b mem=%b",
               req, ea, ea_valid, is_mem, exp_ea, exp_v, exp_m);
    end
  endtask

  task automatic apply(string req, logic [2:0] m, logic [7:0] b0, logic [7:0] b1,
                       logic [15:0] oa, logic [15:0] pc, logic [15:0] x, logic [15:0] y,
                       logic sy, logic tk, logic [15:0] exp_ea, logic exp_m);
    mode = m; opnd0 = b0; opnd1 = b1; opnd_addr = oa; pc_next = pc;
    ix = x; iy = y; sel_y = sy; br_taken = tk; in_valid = 1'b1;
    @(negedge clk);
    check(req, exp_ea, 1'b1, exp_m);
    in_valid = 1'b0;
  endtask

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog: ea=%h expected completion", ea);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    logic        prev_m;
    repeat (3) @(negedge clk);
    check("R12 reset", 16'h0000, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", 16'h0000, 1'b0, 1'b0);

    for (int i = 0; i < 256; i++) begin
      apply("R2 direct", 3'd2, i[7:0], 8'hA5, 16'h1234, 16'h4321, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1,
            {8'h00, i[7:0]}, 1'b1);
    end
    apply("R3 extended", 3'd3, 8'hBE, 8'hEF, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 16'hBEEF, 1'b1);
    apply("R3 extended", 3'd3, 8'h01, 8'h80, 16'h0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b1, 16'h0180, 1'b1);
    apply("R7 immediate", 3'd1, 8'h55, 8'h66, 16'hC001, 16'h9000, 16'h0, 16'h0, 1'b0, 1'b0, 16'hC001, 1'b1);
    apply("R7 immediate", 3'd1, 8'h00, 8'h00, 16'hFFFF, 16'h0001, 16'h0, 16'h0, 1'b1, 1'b0, 16'hFFFF, 1'b1);

    for (int i = 0; i < 256; i++) begin
      apply("R4 indexed ix", 3'd4, i[7:0], 8'h00, 16'h0, 16'h0, 16'h2000, 16'h7000, 1'b0, 1'b0,
            16'h2000 + 16'(i), 1'b1);
      apply("R4 indexed iy", 3'd4, i[7:0], 8'h00, 16'h0, 16'h0, 16'h2000, 16'h7000, 1'b1, 1'b0,
            16'h7000 + 16'(i), 1'b1);
      apply("R10 indexed wrap", 3'd4, i[7:0], 8'h00, 16'h0, 16'h0, 16'h1111, 16'hFF80, 1'b1, 1'b0,
            16'(32'hFF80 + i), 1'b1);
    end

    for (int i = 0; i < 256; i++) begin
      int s;
      s = (i < 128) ? i : i - 256;
      apply("R5 relative taken", 3'd5, i[7:0], 8'h00, 16'h0, 16'h4000, 16'h0, 16'h0, 1'b0, 1'b1,
            16'(32'h4000 + s), 1'b0);
      apply("R10 relative wrap low", 3'd5, i[7:0], 8'h00, 16'h0, 16'h0010, 16'h0, 16'h0, 1'b0, 1'b1,
            16'(32'h10010 + s), 1'b0);
      apply("R10 relative wrap high", 3'd5, i[7:0], 8'h00, 16'h0, 16'hFFF0, 16'h0, 16'h0, 1'b1, 1'b1,
            16'(32'hFFF0 + s), 1'b0);
      apply("R6 relative not taken", 3'd5, i[7:0], 8'h00, 16'h0, 16'h4000, 16'h0, 16'h0, 1'b0, 1'b0,
            16'h4000, 1'b0);
    end

    apply("R9 setup", 3'd3, 8'h12, 8'h34, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 16'h1234, 1'b1);
    apply("R8 inherent", 3'd0, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 16'h0000, 1'b0);
    apply("R9 setup", 3'd2, 8'h77, 8'h00, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 16'h0077, 1'b1);
    apply("R8 unused 6", 3'd6, 8'hAA, 8'hBB, 16'h1234, 16'h5678, 16'h1, 16'h2, 1'b0, 1'b1, 16'h0000, 1'b0);
    apply("R9 setup", 3'd4, 8'h01, 8'h00, 16'h0, 16'h0, 16'h0100, 16'h0, 1'b0, 1'b0, 16'h0101, 1'b1);
    apply("R8 unused 7", 3'd7, 8'hAA, 8'hBB, 16'h1234, 16'h5678, 16'h1, 16'h2, 1'b1, 1'b1, 16'h0000, 1'b0);

    apply("R11 setup", 3'd3, 8'hCA, 8'hFE, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 16'hCAFE, 1'b1);
    prev = ea; prev_m = is_mem;
    for (int k = 0; k < 4; k++) begin
      mode = 3'(k + 1); opnd0 = 8'(k * 37); opnd1 = 8'h11; ix = 16'h3333; pc_next = 16'h8888;
      @(negedge clk);
      check("R11 hold / R1 no valid", prev, 1'b0, prev_m);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule